// File: doc/BRIEF.md
# Memory bank access controller

This block controls the bus cycles of one memory bank on a simple synchronous bus. A configuration word for the bank is loaded into an internal register. It holds a valid bit, a write lock, a long-burst select, the byte strobe function, the burst-progress pacing, an external-acknowledge select, a burst refusal bit and a wait-state count. Address decoding happens outside the block and arrives here as a match flag.

A transfer begins when the start strobe and the match flag are both high in one clock. If the bank is valid and the write lock does not block the access, the block opens the bank for one beat or for a burst of 4 or 8 beats. While the bank is open it drives chip select, the byte strobes, the burst-progress strobe and the transfer acknowledge. The first acknowledge waits for the programmed wait states, and the remaining beats follow on back-to-back clocks. In external-acknowledge mode the beats are paced by an acknowledge input instead. A blocked write sets a sticky error flag, which software clears by writing 1.

Top module: `mbank_ctrl`

## Requirements
- R1: While the valid bit is 0, a start strobe causes no chip select and no acknowledge. The valid bit is 0 after reset.
- R2: If the write lock is set, a write start causes no chip select, no acknowledge and no byte strobe, and `wp_err_o` reads 1 from the next clock on. With the lock set, reads run as normal.
- R3: `wp_err_o` stays at 1 until a clock in which `wp_clr_i` is 1. In a clock where a new blocked write and a clear coincide, the new error wins. The flag is 0 after reset.
- R4: Take the start clock as cycle 0 and the wait count as W. In internal mode, `cs_o` is 1 in cycles 1 to W+n and `ta_o` is 1 in cycles W+1 to W+n, where n is the beat count. `cs_o` is 0 in cycle W+n+1.
- R5: The beat count n is 1 unless `burst_req_i`, `burst_en_i` are 1 and the burst refusal bit is 0. In that case n is 8 when the long-burst bit is 1 and 4 when it is 0.
- R6: `be_o` carries the `byte_en_i` value captured at the start clock while `cs_o` is 1. This holds only on writes when the strobe function bit is 0, and on every transfer when it is 1. In all other cycles `be_o` is 0.
- R7: With both pacing bits 0 (normal), a burst drives `bdip_o` high in cycles 1 to W+n-1.
- R8: With the late bit set, a burst drives `bdip_o` high only in cycles W+1 to W+n-1, once the wait states have run out.
- R9: With the toggle bit set, `bdip_o` is high only in a clock where a beat is acknowledged and that beat is not the last one.
- R10: `cfg_err_o` is 1 exactly while both the late and the toggle pacing bits are set. That combination is illegal, and the pacing it produces is undefined.
- R11: With the external-acknowledge bit set, `ta_o` stays 0. Each clock with `ext_ta_i` high while the bank is open completes one beat. `cs_o` falls in the clock after the last beat.
- R12: `bi_no` is the inverse of the burst refusal bit. That bit resets to 1, so `bi_no` is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_load_i | input | 1 | Loads the configuration fields below |
| cfg_valid_i | input | 1 | Bank valid |
| cfg_wprot_i | input | 1 | Write lock |
| cfg_blen8_i | input | 1 | 1: bursts of 8 beats, 0: bursts of 4 beats |
| cfg_bsel_i | input | 1 | 1: strobes act as byte selects, 0: strobes act as write enables |
| cfg_late_bdip_i | input | 1 | Late burst-progress pacing |
| cfg_tog_bdip_i | input | 1 | Per-beat burst-progress pacing |
| cfg_ext_ack_i | input | 1 | Acknowledge comes from outside the block |
| cfg_binh_i | input | 1 | Refuse bursts |
| cfg_wait_i | input | 4 | Wait states before the first beat |
| burst_en_i | input | 1 | Global burst enable |
| ts_i | input | 1 | Transfer start strobe |
| match_i | input | 1 | Address hits this bank |
| write_i | input | 1 | 1: write, 0: read |
| burst_req_i | input | 1 | Master requests a burst |
| byte_en_i | input | 4 | Byte lanes of the transfer |
| ext_ta_i | input | 1 | External acknowledge |
| wp_clr_i | input | 1 | Write 1 to clear the write-lock error |
| cs_o | output | 1 | Chip select |
| be_o | output | 4 | Write-enable or byte-select strobes |
| bi_no | output | 1 | Burst refused, active low |
| bdip_o | output | 1 | Burst data in progress |
| ta_o | output | 1 | Internal transfer acknowledge |
| wp_err_o | output | 1 | Sticky write-lock error |
| cfg_err_o | output | 1 | Illegal pacing combination |

## Verification
Every output is a decode of registered state, so a start strobe seen at an edge shows first in cycle 1. In internal mode the acknowledge is due in cycles W+1 to W+n, and chip select falls in cycle W+n+1. In external mode the acknowledge follows `ext_ta_i` in the same cycle. The bench drives the inputs at the falling edge and samples one nanosecond later. For each cycle number it compares the outputs against the values it computes from W, n and the pacing mode. Each sweep runs through cycle W+n+1 to catch a chip select that is held too long. The error flag is checked from cycle 1 onward, and a configuration load takes effect one edge after it is applied.

// File: rtl/mbank_pkg.sv
package mbank_pkg;
  localparam int unsigned WAIT_W = 4;

  typedef enum logic [1:0] {
    BDIP_NORM = 2'd0,
    BDIP_LATE = 2'd1,
    BDIP_TOG  = 2'd2
  } bdip_mode_e;

  typedef struct packed {
    logic              valid;
    logic              wprot;
    logic              blen8;
    logic              bsel;
    logic              late;
    logic              tog;
    logic              ext_ack;
    logic              binh;
    logic [WAIT_W-1:0] wait_st;
  } cfg_t;

  localparam cfg_t CFG_RST = '{valid: 1'b0, wprot: 1'b0, blen8: 1'b0, bsel: 1'b0,
                               late: 1'b0, tog: 1'b0, ext_ack: 1'b0, binh: 1'b1,
                               wait_st: '0};
endpackage

// File: rtl/mbank_cfg.sv
module mbank_cfg
  import mbank_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  cfg_t       cfg_d_i,
  output cfg_t       cfg_q_o,
  output bdip_mode_e mode_o,
  output logic       conflict_o
);
  cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cfg_q <= CFG_RST;
    else if (load_i) cfg_q <= cfg_d_i;
  end

  // toggle wins when both pacing bits are set
  always_comb begin
    if (cfg_q.tog)       mode_o = BDIP_TOG;
    else if (cfg_q.late) mode_o = BDIP_LATE;
    else                 mode_o = BDIP_NORM;
  end

  assign conflict_o = cfg_q.tog & cfg_q.late;
  assign cfg_q_o    = cfg_q;
endmodule

// File: rtl/mbank_seq.sv
module mbank_seq #(
  parameter int unsigned NBYTE       = 4,
  parameter int unsigned BEATS_SHORT = 4,
  parameter int unsigned BEATS_LONG  = 8,
  parameter int unsigned WAIT_W      = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ts_i,
  input  logic              match_i,
  input  logic              write_i,
  input  logic              burst_req_i,
  input  logic              burst_en_i,
  input  logic [NBYTE-1:0]  byte_en_i,
  input  logic              ext_ta_i,
  input  logic              valid_i,
  input  logic              wprot_i,
  input  logic              blen8_i,
  input  logic              binh_i,
  input  logic              ext_ack_i,
  input  logic [WAIT_W-1:0] wait_st_i,
  output logic              active_o,
  output logic              write_o,
  output logic              burst_o,
  output logic              last_o,
  output logic              wait_done_o,
  output logic              ack_o,
  output logic [NBYTE-1:0]  be_o,
  output logic              wp_hit_o
);
  localparam int unsigned CNT_W = $clog2(BEATS_LONG + 1);

  logic              active_q, write_q, burst_q;
  logic [WAIT_W-1:0] wcnt_q;
  logic [CNT_W-1:0]  beat_q, nbeats_q, nbeats_d;
  logic [NBYTE-1:0]  be_q;
  logic              hit, start, burst_ok, wait_done, ack, last;

  assign hit       = ts_i && match_i && !active_q && valid_i;
  assign wp_hit_o  = hit && write_i && wprot_i;
  assign start     = hit && !(write_i && wprot_i);
  assign burst_ok  = burst_req_i && burst_en_i && !binh_i;
  assign nbeats_d  = !burst_ok ? CNT_W'(1) :
                     blen8_i   ? CNT_W'(BEATS_LONG) : CNT_W'(BEATS_SHORT);
  assign wait_done = (wcnt_q == '0);
  assign ack       = active_q && (ext_ack_i ? ext_ta_i : wait_done);
  assign last      = (beat_q == nbeats_q - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      write_q  <= 1'b0;
      burst_q  <= 1'b0;
      wcnt_q   <= '0;
      beat_q   <= '0;
      nbeats_q <= CNT_W'(1);
      be_q     <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      write_q  <= write_i;
      burst_q  <= burst_ok;
      wcnt_q   <= wait_st_i;
      beat_q   <= '0;
      nbeats_q <= nbeats_d;
      be_q     <= byte_en_i;
    end else if (active_q) begin
      if (!wait_done) wcnt_q <= wcnt_q - WAIT_W'(1);
      if (ack) begin
        if (last) active_q <= 1'b0;
        else      beat_q   <= beat_q + CNT_W'(1);
      end
    end
  end

  assign active_o    = active_q;
  assign write_o     = write_q;
  assign burst_o     = burst_q;
  assign last_o      = last;
  assign wait_done_o = wait_done;
  assign ack_o       = ack;
  assign be_o        = be_q;
endmodule

// File: rtl/mbank_strobe.sv
module mbank_strobe
  import mbank_pkg::*;
#(
  parameter int unsigned NBYTE = 4
) (
  input  logic             active_i,
  input  logic             write_i,
  input  logic             burst_i,
  input  logic             last_i,
  input  logic             wait_done_i,
  input  logic             ack_i,
  input  logic [NBYTE-1:0] be_i,
  input  logic             bsel_i,
  input  logic             ext_ack_i,
  input  logic             binh_i,
  input  bdip_mode_e       mode_i,
  output logic             cs_o,
  output logic [NBYTE-1:0] be_o,
  output logic             bi_no,
  output logic             bdip_o,
  output logic             ta_o
);
  logic pace;

  always_comb begin
    unique case (mode_i)
      BDIP_LATE: pace = wait_done_i;
      BDIP_TOG:  pace = ack_i;
      default:   pace = 1'b1;
    endcase
  end

  assign cs_o   = active_i;
  assign ta_o   = active_i && !ext_ack_i && wait_done_i;
  assign bi_no  = !binh_i;
  assign be_o   = (active_i && (bsel_i || write_i)) ? be_i : '0;
  assign bdip_o = active_i && burst_i && !last_i && pace;
endmodule

// File: rtl/mbank_wperr.sv
module mbank_wperr (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end
endmodule

// File: rtl/mbank_ctrl.sv
module mbank_ctrl
  import mbank_pkg::*;
#(
  parameter int unsigned NBYTE       = 4,
  parameter int unsigned BEATS_SHORT = 4,
  parameter int unsigned BEATS_LONG  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_load_i,
  input  logic              cfg_valid_i,
  input  logic              cfg_wprot_i,
  input  logic              cfg_blen8_i,
  input  logic              cfg_bsel_i,
  input  logic              cfg_late_bdip_i,
  input  logic              cfg_tog_bdip_i,
  input  logic              cfg_ext_ack_i,
  input  logic              cfg_binh_i,
  input  logic [WAIT_W-1:0] cfg_wait_i,
  input  logic              burst_en_i,
  input  logic              ts_i,
  input  logic              match_i,
  input  logic              write_i,
  input  logic              burst_req_i,
  input  logic [NBYTE-1:0]  byte_en_i,
  input  logic              ext_ta_i,
  input  logic              wp_clr_i,
  output logic              cs_o,
  output logic [NBYTE-1:0]  be_o,
  output logic              bi_no,
  output logic              bdip_o,
  output logic              ta_o,
  output logic              wp_err_o,
  output logic              cfg_err_o
);
  cfg_t             cfg_d, cfg_q;
  bdip_mode_e       mode;
  logic             active, wr_q, burst_q, last, wait_done, ack, wp_hit;
  logic [NBYTE-1:0] be_q;

  assign cfg_d = '{valid: cfg_valid_i, wprot: cfg_wprot_i, blen8: cfg_blen8_i,
                   bsel: cfg_bsel_i, late: cfg_late_bdip_i, tog: cfg_tog_bdip_i,
                   ext_ack: cfg_ext_ack_i, binh: cfg_binh_i, wait_st: cfg_wait_i};

  mbank_cfg u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (cfg_load_i),
    .cfg_d_i    (cfg_d),
    .cfg_q_o    (cfg_q),
    .mode_o     (mode),
    .conflict_o (cfg_err_o)
  );

  mbank_seq #(
    .NBYTE       (NBYTE),
    .BEATS_SHORT (BEATS_SHORT),
    .BEATS_LONG  (BEATS_LONG),
    .WAIT_W      (WAIT_W)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ts_i        (ts_i),
    .match_i     (match_i),
    .write_i     (write_i),
    .burst_req_i (burst_req_i),
    .burst_en_i  (burst_en_i),
    .byte_en_i   (byte_en_i),
    .ext_ta_i    (ext_ta_i),
    .valid_i     (cfg_q.valid),
    .wprot_i     (cfg_q.wprot),
    .blen8_i     (cfg_q.blen8),
    .binh_i      (cfg_q.binh),
    .ext_ack_i   (cfg_q.ext_ack),
    .wait_st_i   (cfg_q.wait_st),
    .active_o    (active),
    .write_o     (wr_q),
    .burst_o     (burst_q),
    .last_o      (last),
    .wait_done_o (wait_done),
    .ack_o       (ack),
    .be_o        (be_q),
    .wp_hit_o    (wp_hit)
  );

  mbank_strobe #(.NBYTE(NBYTE)) u_strobe (
    .active_i    (active),
    .write_i     (wr_q),
    .burst_i     (burst_q),
    .last_i      (last),
    .wait_done_i (wait_done),
    .ack_i       (ack),
    .be_i        (be_q),
    .bsel_i      (cfg_q.bsel),
    .ext_ack_i   (cfg_q.ext_ack),
    .binh_i      (cfg_q.binh),
    .mode_i      (mode),
    .cs_o        (cs_o),
    .be_o        (be_o),
    .bi_no       (bi_no),
    .bdip_o      (bdip_o),
    .ta_o        (ta_o)
  );

  mbank_wperr u_wperr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (wp_hit),
    .clr_i  (wp_clr_i),
    .flag_o (wp_err_o)
  );
endmodule

// File: rtl/mbank_ctrl_chk.sv
module mbank_ctrl_chk
  import mbank_pkg::*;
#(
  parameter int unsigned NBYTE = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ts_i,
  input logic             match_i,
  input logic             write_i,
  input logic             ext_ta_i,
  input logic             wp_clr_i,
  input logic             cs_o,
  input logic             ta_o,
  input logic             bdip_o,
  input logic [NBYTE-1:0] be_o,
  input logic             wp_err_o,
  input cfg_t             cfg_q
);
  AST_CS_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_o |-> cfg_q.valid); // R1
  AST_WP_BLOCKS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ts_i && match_i && !cs_o && write_i && cfg_q.valid && cfg_q.wprot) |=> (!cs_o && wp_err_o)); // R2
  AST_WP_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wp_err_o && !wp_clr_i) |=> wp_err_o); // R3
  AST_TA_INSIDE_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ta_o |-> cs_o); // R4
  AST_CS_ENDS_ON_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_o) |-> $past(ta_o || (cfg_q.ext_ack && ext_ta_i))); // R4
  AST_BE_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_o |-> (be_o == '0)); // R6
  AST_BDIP_INSIDE_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bdip_o |-> cs_o); // R7
  AST_EXT_NO_TA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q.ext_ack |-> !ta_o); // R11
endmodule

bind mbank_ctrl mbank_ctrl_chk #(.NBYTE(NBYTE)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ts_i     (ts_i),
  .match_i  (match_i),
  .write_i  (write_i),
  .ext_ta_i (ext_ta_i),
  .wp_clr_i (wp_clr_i),
  .cs_o     (cs_o),
  .ta_o     (ta_o),
  .bdip_o   (bdip_o),
  .be_o     (be_o),
  .wp_err_o (wp_err_o),
  .cfg_q    (cfg_q)
);

// File: tb/mbank_ctrl_bench.sv
module mbank_ctrl_bench;
  localparam int NBYTE = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic cfg_load = 0, c_valid = 0, c_wprot = 0, c_blen8 = 0, c_bsel = 0;
  logic c_late = 0, c_tog = 0, c_ext = 0, c_binh = 1;
  logic [3:0] c_wait = '0;
  logic burst_en = 0, ts = 0, match = 0, wr = 0, breq = 0, ext_ta = 0, wp_clr = 0;
  logic [NBYTE-1:0] byte_en = '0;
  logic cs, bi_n, bdip, ta, wp_err, cfg_err;
  logic [NBYTE-1:0] be;

  int n_chk = 0;
  int n_fail = 0;

  mbank_ctrl u_mbank_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cfg_load_i(cfg_load), .cfg_valid_i(c_valid),
    .cfg_wprot_i(c_wprot), .cfg_blen8_i(c_blen8), .cfg_bsel_i(c_bsel),
    .cfg_late_bdip_i(c_late), .cfg_tog_bdip_i(c_tog), .cfg_ext_ack_i(c_ext),
    .cfg_binh_i(c_binh), .cfg_wait_i(c_wait), .burst_en_i(burst_en), .ts_i(ts),
    .match_i(match), .write_i(wr), .burst_req_i(breq), .byte_en_i(byte_en),
    .ext_ta_i(ext_ta), .wp_clr_i(wp_clr), .cs_o(cs), .be_o(be), .bi_no(bi_n),
    .bdip_o(bdip), .ta_o(ta), .wp_err_o(wp_err), .cfg_err_o(cfg_err)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic load(input bit v, input bit wp, input bit b8, input bit bs, input bit lt,
                      input bit tg, input bit ex, input bit bi, input int w);
    @(negedge clk);
    c_valid = v; c_wprot = wp; c_blen8 = b8; c_bsel = bs; c_late = lt; c_tog = tg;
    c_ext = ex; c_binh = bi; c_wait = 4'(w); cfg_load = 1; wp_clr = 1;
    @(negedge clk);
    cfg_load = 0; wp_clr = 0;
  endtask

  // internal-acknowledge access, mode 0 normal, 1 late, 2 toggle
  task automatic run_int(input int w, input bit b8, input bit rq, input bit ben, input bit bi,
                         input bit wp, input int mode, input bit w_r, input bit bs,
                         input logic [NBYTE-1:0] pat);
    int  n;
    bit  blocked;
    string breq_tag;
    n = (rq && ben && !bi) ? (b8 ? 8 : 4) : 1;
    blocked = w_r && wp;
    breq_tag = rq ? "R5" : "R4";
    load(1, wp, b8, bs, mode == 1, mode == 2, 0, bi, w);
    @(negedge clk);
    ts = 1; match = 1; wr = w_r; breq = rq; burst_en = ben; byte_en = pat;
    #1;
    chk("R4", "cs cycle0", cs, 0);
    chk("R3", "wp_err cycle0", wp_err, 0);
    chk("R12", "bi_n", bi_n, !bi);
    for (int c = 1; c <= w + n + 1; c++) begin
      bit e_cs, e_ta, e_bd;
      @(negedge clk);
      ts = 0; match = 0;
      #1;
      e_cs = !blocked && (c <= w + n);
      e_ta = !blocked && (c >= w + 1) && (c <= w + n);
      if (mode == 0) e_bd = !blocked && (n > 1) && (c <= w + n - 1);
      else           e_bd = !blocked && (n > 1) && (c >= w + 1) && (c <= w + n - 1);
      chk(blocked ? "R2" : "R4", "cs", cs, e_cs);
      chk(blocked ? "R2" : breq_tag, "ta", ta, e_ta);
      chk(mode == 0 ? "R7" : (mode == 1 ? "R8" : "R9"), "bdip", bdip, e_bd);
      chk("R6", "be", be, (e_cs && (bs || w_r)) ? pat : '0);
      chk("R2", "wp_err", wp_err, blocked);
    end
  endtask

  initial begin
    #700000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk("R12", "bi_n after reset", bi_n, 0);
    chk("R1", "cs after reset", cs, 0);
    chk("R3", "wp_err after reset", wp_err, 0);
    chk("R10", "cfg_err after reset", cfg_err, 0);
    // start with reset configuration: bank not valid
    @(negedge clk); ts = 1; match = 1;
    for (int c = 1; c <= 3; c++) begin
      @(negedge clk); ts = 0; match = 0; #1;
      chk("R1", "cs invalid after reset", cs, 0);
      chk("R1", "ta invalid after reset", ta, 0);
    end

    // R1: explicitly cleared valid bit
    load(0, 0, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk); ts = 1; match = 1; breq = 1; burst_en = 1;
    for (int c = 1; c <= 6; c++) begin
      @(negedge clk); ts = 0; match = 0; #1;
      chk("R1", "cs invalid", cs, 0);
      chk("R1", "ta invalid", ta, 0);
    end

    // main sweep
    for (int w = 0; w < 16; w++)
      for (int b8 = 0; b8 < 2; b8++)
        for (int rq = 0; rq < 2; rq++)
          for (int m = 0; m < 3; m++)
            for (int w_r = 0; w_r < 2; w_r++)
              for (int bs = 0; bs < 2; bs++)
                run_int(w, b8[0], rq[0], 1, 0, 0, m, w_r[0], bs[0], 4'(w) | 4'b1000);

    // R5: bursts refused by global enable or by the refusal bit
    for (int w = 0; w < 4; w++) begin
      run_int(w, 1, 1, 0, 0, 0, 0, 0, 1, 4'b0101);
      run_int(w, 1, 1, 1, 1, 0, 0, 1, 0, 4'b0011);
    end

    // R2: blocked writes, reads still served under the lock
    for (int w = 0; w < 4; w++) begin
      run_int(w, 0, 1, 1, 0, 1, 0, 1, 1, 4'b1111);
      run_int(w, 0, 1, 1, 0, 1, 0, 0, 1, 4'b1001);
    end

    // R3: sticky flag, clear, and set winning over clear
    load(1, 1, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk); ts = 1; match = 1; wr = 1;
    @(negedge clk); ts = 0; match = 0; wr = 0;
    repeat (3) @(negedge clk);
    #1 chk("R3", "wp_err held", wp_err, 1);
    @(negedge clk); wp_clr = 1;
    @(negedge clk); wp_clr = 0; #1;
    chk("R3", "wp_err cleared", wp_err, 0);
    @(negedge clk); ts = 1; match = 1; wr = 1; wp_clr = 1;
    @(negedge clk); ts = 0; match = 0; wr = 0; wp_clr = 0; #1;
    chk("R3", "set beats clear", wp_err, 1);

    // R10: illegal pacing flag
    load(1, 0, 0, 0, 1, 1, 0, 0, 0);
    #1 chk("R10", "cfg_err both", cfg_err, 1);
    load(1, 0, 0, 0, 1, 0, 0, 0, 0);
    #1 chk("R10", "cfg_err late only", cfg_err, 0);

    // R11 + R9: external acknowledge with gaps, toggle pacing, 4-beat burst
    load(1, 0, 0, 0, 0, 1, 1, 0, 2);
    @(negedge clk);
    ts = 1; match = 1; wr = 0; breq = 1; burst_en = 1;
    begin
      int acks;
      acks = 0;
      for (int c = 1; c <= 9; c++) begin
        bit e_cs;
        @(negedge clk);
        ts = 0; match = 0;
        ext_ta = (c == 2) || (c == 4) || (c == 5) || (c == 7);
        #1;
        e_cs = acks < 4;
        chk("R11", "cs ext", cs, e_cs);
        chk("R11", "ta ext", ta, 0);
        chk("R9", "bdip toggle ext", bdip, e_cs && ext_ta && (acks < 3));
        if (e_cs && ext_ta) acks++;
      end
      ext_ta = 0;
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule